// File: doc/BRIEF.md
# PAM4 Bit-to-Symbol Mapper

This block turns a serial stream of binary bits into a stream of four-level pulse-amplitude symbols. It takes two bits for each symbol, so symbols leave at half the rate that bits are accepted. Each symbol comes out in two forms: a small signed level code from the set {-3, -1, +1, +3}, and a signed fixed-point amplitude placed at plus or minus full scale or plus or minus one third of full scale.

The bit pair can be mapped in plain binary order or in Gray order. In Gray order, neighbouring levels differ in a single bit. A third setting, NRZ fallback, keeps only the two outer levels so that the stream can talk to a two-level receiver. Both selects are sampled once per pair, at the pair's first bit. Bits enter through a valid/ready handshake. Symbols leave as a one-cycle valid pulse with no back-pressure.

Top module: `pam4_symbol_mapper`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sym_valid_o` and `bit_ready_o` are 0 after that edge. `bit_ready_o` is 1 from the first edge that sees `rst_n` high.
- R2: A bit is accepted on an edge where `bit_valid_i` and `bit_ready_o` are both 1. The first accepted bit of a pair is the high bit. `sym_valid_o` is 1 for exactly the one cycle that follows the edge accepting the second bit, and is 0 in every other cycle.
- R3: With Gray coding selected (`gray_sel_i`=1, `nrz_mode_i`=0), the pair (high,low) maps as 00 to -3, 01 to -1, 11 to +1 and 10 to +3.
- R4: With linear coding selected (`gray_sel_i`=0, `nrz_mode_i`=0), the pair maps as 00 to -3, 01 to -1, 10 to +1 and 11 to +3. `sym_level_o` is a 3-bit two's-complement value: -3=101, -1=111, +1=001, +3=011.
- R5: With `nrz_mode_i`=1, the low bit of the pair is treated as 0 and the Gray table is used, whatever `gray_sel_i` is. A high bit of 0 gives -3 and a high bit of 1 gives +3. The value of the second bit has no effect.
- R6: `sym_amp_o` is 16-bit two's complement. With the default full-scale code of 16384 (0.5), it is +16384 for +3, +5461 for +1, -5461 for -1 and -16384 for -3. One third of full scale is rounded to the nearest code.
- R7: `gray_sel_i` and `nrz_mode_i` are sampled on the edge that accepts a pair's first bit. A change while the pair is open acts only on the next pair.
- R8: A single bit held when reset is applied is discarded. The first two bits accepted after reset form the next symbol.
- R9: Cycles with `bit_valid_i`=0 consume no bit and emit no symbol, whatever `bit_data_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_valid_i | input | 1 | Input bit present |
| bit_data_i | input | 1 | Input bit value |
| bit_ready_o | output | 1 | Block can take a bit |
| gray_sel_i | input | 1 | 1 = Gray coding, 0 = linear coding |
| nrz_mode_i | input | 1 | 1 = outer levels only (NRZ fallback) |
| sym_valid_o | output | 1 | Symbol present, one-cycle pulse |
| sym_level_o | output | 3 | Signed level code (-3, -1, +1, +3) |
| sym_amp_o | output | 16 | Signed fixed-point amplitude |

## Verification
Two events can fall in the same cycle. One is a coding or mode change arriving together with the bit that closes a pair. The other is a reset arriving while a pair is half collected. The bench flips `gray_sel_i` on the cycle of a pair's second bit, using bits 11, which give +1 under Gray and +3 under linear. It expects the coding that was in force at the first bit, and expects the new coding on the pair after. For the second case it applies reset after one bit and then sends a pair whose result would differ if the stale bit were kept.

// File: rtl/pam4_map_pkg.sv
// Shared types and helpers for the PAM4 symbol mapper.
// Assumes the level index runs 0..3 from the lowest to the highest level.
package pam4_map_pkg;

    // Level position, lowest first
    typedef enum logic [1:0] {
        LVL_M3 = 2'd0,
        LVL_M1 = 2'd1,
        LVL_P1 = 2'd2,
        LVL_P3 = 2'd3
    } lvl_idx_t;

    // Coding selection captured once per pair
    typedef struct packed {
        logic gray;
        logic nrz;
    } code_cfg_t;

    // Signed 3-bit level code for a level position
    function automatic logic [2:0] idx_to_code(lvl_idx_t idx);
        logic [2:0] code;
        case (idx)
            LVL_M3:  code = 3'b101;
            LVL_M1:  code = 3'b111;
            LVL_P1:  code = 3'b001;
            default: code = 3'b011;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/pam4_pair_collector.sv
// Collects serial bits into pairs, with the first bit as the high bit.
// Captures the coding selection with the first bit of each pair.
// Assumes the downstream logic takes a finished pair in the same cycle.
// A half-collected pair is lost on reset.
module pam4_pair_collector
    import pam4_map_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_valid_i,
    input  logic      bit_data_i,
    input  logic      gray_sel_i,
    input  logic      nrz_mode_i,
    output logic      ready_o,
    output logic      pair_fire_o,
    output logic [1:0] pair_bits_o,
    output code_cfg_t cfg_o
);

    logic      ready_q;
    logic      have_hi_q;
    logic      hi_bit_q;
    code_cfg_t cfg_q;
    logic      accept;

    assign accept = bit_valid_i && ready_q;

    // Ready rises on the first edge out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Track the open pair; hold its high bit and the coding chosen for it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_hi_q <= 1'b0;
            hi_bit_q  <= 1'b0;
            cfg_q     <= '0;
        end else if (accept) begin
            if (!have_hi_q) begin
                have_hi_q <= 1'b1;
                hi_bit_q  <= bit_data_i;
                cfg_q     <= '{gray: gray_sel_i, nrz: nrz_mode_i};
            end else begin
                have_hi_q <= 1'b0;
            end
        end
    end

    assign ready_o     = ready_q;
    assign pair_fire_o = accept && have_hi_q;
    assign pair_bits_o = {hi_bit_q, bit_data_i};
    assign cfg_o       = cfg_q;

endmodule

// File: rtl/pam4_level_encoder.sv
// Maps a bit pair to a level position under linear, Gray or NRZ coding.
// NRZ forces the low bit to zero and uses the Gray table, so only the
// outer levels occur. Purely combinational.
module pam4_level_encoder
    import pam4_map_pkg::*;
(
    input  logic [1:0] pair_bits_i,
    input  code_cfg_t  cfg_i,
    output lvl_idx_t   idx_o
);

    logic [1:0] eff_bits;

    // Choose the effective pair and apply the chosen table
    always_comb begin
        eff_bits = cfg_i.nrz ? {pair_bits_i[1], 1'b0} : pair_bits_i;
        if (cfg_i.gray || cfg_i.nrz)
            idx_o = lvl_idx_t'({eff_bits[1], eff_bits[1] ^ eff_bits[0]});
        else
            idx_o = lvl_idx_t'(eff_bits);
    end

endmodule

// File: rtl/pam4_amp_scaler.sv
// Turns a level position into a signed fixed-point amplitude.
// The outer levels sit at plus or minus FS_CODE and the inner ones at
// plus or minus FS_CODE/3, rounded to the nearest code.
// Assumes FS_CODE fits in AMP_W-1 bits.
module pam4_amp_scaler
    import pam4_map_pkg::*;
#(
    parameter int AMP_W   = 16,
    parameter int FS_CODE = 16384
) (
    input  lvl_idx_t          idx_i,
    output logic [AMP_W-1:0]  amp_o
);

    localparam int NUM_LVL  = 4;
    localparam int FS_THIRD = (2 * FS_CODE + 3) / 6;

    logic [AMP_W-1:0] amp_tab [NUM_LVL];

    // One constant per level position, lowest first
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        localparam int VAL = (g == 0) ? -FS_CODE :
                             (g == 1) ? -FS_THIRD :
                             (g == 2) ?  FS_THIRD : FS_CODE;
        assign amp_tab[g] = VAL[AMP_W-1:0];
    end

    assign amp_o = amp_tab[idx_i];

endmodule

// File: rtl/pam4_symbol_mapper.sv
// Top level of the PAM4 bit-to-symbol mapper.
// Takes bits through a valid/ready handshake and emits one registered
// symbol (level code and amplitude) per two bits, as a one-cycle pulse.
// Assumes the receiver of symbols never stalls.
module pam4_symbol_mapper
    import pam4_map_pkg::*;
#(
    parameter int AMP_W   = 16,
    parameter int FS_CODE = 16384
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_valid_i,
    input  logic                    bit_data_i,
    output logic                    bit_ready_o,
    input  logic                    gray_sel_i,
    input  logic                    nrz_mode_i,
    output logic                    sym_valid_o,
    output logic signed [2:0]       sym_level_o,
    output logic signed [AMP_W-1:0] sym_amp_o
);

    logic             pair_fire;
    logic [1:0]       pair_bits;
    code_cfg_t        pair_cfg;
    lvl_idx_t         lvl_idx;
    logic [AMP_W-1:0] amp_next;

    pam4_pair_collector u_collect (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_valid_i (bit_valid_i),
        .bit_data_i  (bit_data_i),
        .gray_sel_i  (gray_sel_i),
        .nrz_mode_i  (nrz_mode_i),
        .ready_o     (bit_ready_o),
        .pair_fire_o (pair_fire),
        .pair_bits_o (pair_bits),
        .cfg_o       (pair_cfg)
    );

    pam4_level_encoder u_encode (
        .pair_bits_i (pair_bits),
        .cfg_i       (pair_cfg),
        .idx_o       (lvl_idx)
    );

    pam4_amp_scaler #(
        .AMP_W   (AMP_W),
        .FS_CODE (FS_CODE)
    ) u_scale (
        .idx_i (lvl_idx),
        .amp_o (amp_next)
    );

    // Register the symbol on the edge that closes a pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_valid_o <= 1'b0;
            sym_level_o <= '0;
            sym_amp_o   <= '0;
        end else begin
            sym_valid_o <= pair_fire;
            if (pair_fire) begin
                sym_level_o <= idx_to_code(lvl_idx);
                sym_amp_o   <= amp_next;
            end
        end
    end

endmodule

// File: rtl/pam4_symbol_mapper_chk.sv
// Property checker for the PAM4 symbol mapper, attached by bind.
module pam4_symbol_mapper_chk #(
    parameter int AMP_W   = 16,
    parameter int FS_CODE = 16384
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bit_valid_i,
    input logic                    bit_ready_o,
    input logic                    sym_valid_o,
    input logic signed [2:0]       sym_level_o,
    input logic signed [AMP_W-1:0] sym_amp_o
);

    localparam int FS_THIRD = (2 * FS_CODE + 3) / 6;

    int exp_amp;

    // Amplitude implied by the level code
    always_comb begin
        case (sym_level_o)
            3'b011:  exp_amp = FS_CODE;
            3'b001:  exp_amp = FS_THIRD;
            3'b111:  exp_amp = -FS_THIRD;
            default: exp_amp = -FS_CODE;
        endcase
    end

    // R1: reset clears the symbol strobe and the ready flag
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!sym_valid_o && !bit_ready_o));

    // R2: a symbol is never two cycles long
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o |=> !sym_valid_o);

    // R2: a symbol follows an accepted bit
    assert_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o |-> $past(bit_valid_i && bit_ready_o));

    // R4: level code is one of the four legal codes
    assert_legal_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o |-> (sym_level_o == 3'sb101 || sym_level_o == 3'sb111 ||
                         sym_level_o == 3'sb001 || sym_level_o == 3'sb011));

    // R6: amplitude agrees with the level code
    assert_amp_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o |-> (int'(sym_amp_o) == exp_amp));

endmodule

bind pam4_symbol_mapper pam4_symbol_mapper_chk #(
    .AMP_W   (AMP_W),
    .FS_CODE (FS_CODE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_valid_i (bit_valid_i),
    .bit_ready_o (bit_ready_o),
    .sym_valid_o (sym_valid_o),
    .sym_level_o (sym_level_o),
    .sym_amp_o   (sym_amp_o)
);

// File: tb/pam4_symbol_mapper_test.sv
// Directed bench for the PAM4 symbol mapper.
module pam4_symbol_mapper_test;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bit_valid_i = 1'b0;
    logic              bit_data_i = 1'b0;
    logic              bit_ready_o;
    logic              gray_sel_i = 1'b0;
    logic              nrz_mode_i = 1'b0;
    logic              sym_valid_o;
    logic signed [2:0] sym_level_o;
    logic signed [15:0] sym_amp_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    pam4_symbol_mapper uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_valid_i (bit_valid_i),
        .bit_data_i  (bit_data_i),
        .bit_ready_o (bit_ready_o),
        .gray_sel_i  (gray_sel_i),
        .nrz_mode_i  (nrz_mode_i),
        .sym_valid_o (sym_valid_o),
        .sym_level_o (sym_level_o),
        .sym_amp_o   (sym_amp_o)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int amp_of(int lvl);
        case (lvl)
            3:  return 16384;
            1:  return 5461;
            -1: return -5461;
            default: return -16384;
        endcase
    endfunction

    // Drive one bit for one cycle and sample just after the edge
    task automatic drive_bit(bit b, bit g, bit n);
        @(negedge clk);
        bit_valid_i = 1'b1;
        bit_data_i  = b;
        gray_sel_i  = g;
        nrz_mode_i  = n;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_cycle(bit junk);
        @(negedge clk);
        bit_valid_i = 1'b0;
        bit_data_i  = junk;
        @(posedge clk);
        #1;
    endtask

    // Send a full pair with steady selects, then check the symbol
    task automatic send_pair(bit hi, bit lo, bit g, bit n, int exp_lvl, string req);
        drive_bit(hi, g, n);
        check({req, " no symbol mid-pair"}, int'(sym_valid_o), 0);
        drive_bit(lo, g, n);
        check({req, " valid"}, int'(sym_valid_o), 1);
        check({req, " level"}, int'(sym_level_o), exp_lvl);
        check({req, " amp R6"}, int'(sym_amp_o), amp_of(exp_lvl));
        idle_cycle(1'b0);
        check({req, " pulse ends R2"}, int'(sym_valid_o), 0);
    endtask

    task automatic t_reset_r1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 ready in reset", int'(bit_ready_o), 0);
        check("R1 valid in reset", int'(sym_valid_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 ready after reset", int'(bit_ready_o), 1);
    endtask

    task automatic t_gray_r3;
        send_pair(0, 0, 1, 0, -3, "R3 gray 00");
        send_pair(0, 1, 1, 0, -1, "R3 gray 01");
        send_pair(1, 1, 1, 0,  1, "R3 gray 11");
        send_pair(1, 0, 1, 0,  3, "R3 gray 10");
    endtask

    task automatic t_linear_r4;
        send_pair(0, 0, 0, 0, -3, "R4 linear 00");
        send_pair(0, 1, 0, 0, -1, "R4 linear 01");
        send_pair(1, 0, 0, 0,  1, "R4 linear 10");
        send_pair(1, 1, 0, 0,  3, "R4 linear 11");
    endtask

    task automatic t_nrz_r5;
        send_pair(1, 1, 0, 1,  3, "R5 nrz linear 11");
        send_pair(1, 0, 1, 1,  3, "R5 nrz gray 10");
        send_pair(0, 1, 0, 1, -3, "R5 nrz linear 01");
        send_pair(0, 0, 1, 1, -3, "R5 nrz gray 00");
    endtask

    // Selects flip on the closing bit; they must act on the next pair only
    task automatic t_mode_change_r7;
        drive_bit(1, 1, 0);
        drive_bit(1, 0, 1);
        check("R7 valid", int'(sym_valid_o), 1);
        check("R7 old coding kept", int'(sym_level_o), 1);
        idle_cycle(1'b1);
        send_pair(1, 1, 0, 0, 3, "R7 new coding next pair");
    endtask

    task automatic t_partial_reset_r8;
        drive_bit(1, 1, 0);
        @(negedge clk);
        bit_valid_i = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R8 no symbol in reset", int'(sym_valid_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        send_pair(0, 1, 1, 0, -1, "R8 stale bit dropped");
    endtask

    task automatic t_gaps_r9;
        drive_bit(1, 0, 0);
        for (int i = 0; i < 3; i++) begin
            idle_cycle(i[0]);
            check("R9 idle no symbol", int'(sym_valid_o), 0);
        end
        drive_bit(0, 0, 0);
        check("R9 valid after gap", int'(sym_valid_o), 1);
        check("R9 level after gap", int'(sym_level_o), 1);
        idle_cycle(1'b1);
        send_pair(0, 0, 0, 0, -3, "R9 alignment kept");
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset_r1();
        t_gray_r3();
        t_linear_r4();
        t_nrz_r5();
        t_mode_change_r7();
        t_partial_reset_r8();
        t_gaps_r9();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule